// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block gathers a large set of peripheral interrupt request lines into a small set of CPU interrupt inputs. The request lines are organised into groups with a fixed number of sources each; the default is twelve groups of eight. Each group drives one CPU interrupt line, so group `g` (counted from 0) drives `cpu_irq[g]`. A few extra request lines bypass the grouping and go straight to the CPU.

Each group holds a per-source pending flag, a per-source enable, and a single in-flight latch. A pending, enabled source fires the group's CPU line only while the latch is clear. Firing sets the latch. Any later work stays pending until software writes 1 to clear the latch, so each group has at most one interrupt outstanding at a time.

When the CPU acknowledges a group by number, the block reports the lowest-numbered enabled pending source of that group and retires that source's flag. A byte-wide register port gives software read and write access to the flags, enables and latches.

Top module: `grpx_irq_expander`

## Requirements
- R1: After reset all flags, enables and in-flight latches read 0, and `cpu_irq` is all zero.
- R2: A high on `src_req[g*8+s]` at a clock edge sets bit `s` of group `g`'s flag register (address `{2'b00,g}`), and the flag stays set. If a software flag write and a hardware request hit the same bit in the same cycle, the bit ends up set.
- R3: A flag whose enable bit (address `{2'b01,g}`) is clear raises no CPU request and stays set. Setting the enable later causes a request one cycle after the enable write takes effect.
- R4: When a group has an enabled pending flag and its latch is clear, `cpu_irq[g]` is high for exactly one cycle. In that same cycle the latch (address `{2'b10,g}`, bit 0) becomes 1.
- R5: While a group's latch is set, `cpu_irq[g]` stays low. Writing 1 to latch bit 0 clears it, and if work is still pending, `cpu_irq[g]` pulses on the second edge after the write.
- R6: A `cpu_ack_valid` with `cpu_ack_grp=g` gives, one cycle later, `ack_hit=1` and `ack_idx` equal to the lowest enabled pending source index, and clears only that flag bit. If no source is enabled and pending, it gives `ack_hit=0` and leaves the flags unchanged.
- R7: `cpu_direct` follows `direct_req` combinationally, with no change.
- R8: Flag and enable writes replace the whole register with `reg_wdata`. An address whose group field is 12 or above, or whose kind field is `2'b11`, ignores writes and reads as 0.
- R9: Groups act independently: a request in one group pulses only that group's CPU line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 96 | Grouped request lines, source s of group g at bit g*8+s |
| direct_req | input | 4 | Non-grouped request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | {kind[1:0], group[3:0]}; kind 0 flag, 1 enable, 2 latch |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cpu_ack_valid | input | 1 | CPU acknowledge strobe |
| cpu_ack_grp | input | 4 | Group being acknowledged |
| ack_hit | output | 1 | Acknowledge found an enabled pending source |
| ack_idx | output | 3 | Winning source index within the group |
| cpu_irq | output | 12 | One-cycle request pulse per group |
| cpu_direct | output | 4 | Pass-through of direct_req |

## Verification
The hardest case to reach is a request that arrives while its group's latch is still set from an earlier interrupt. The bench has to prove that no pulse occurs and that one follows exactly when software releases the latch. To get there, it fires a group, retires the source with a CPU acknowledge, and raises the same source again while the latch is held. It watches the line for several idle cycles, then clears the latch and checks the pulse at a fixed edge. A separate case drives a software clear and a hardware set into the same flag bit in one cycle.

// File: rtl/grpx_pkg.sv
package grpx_pkg;

  // Register kind, taken from the top two address bits
  typedef enum logic [1:0] {
    KIND_FLAG = 2'b00,
    KIND_EN   = 2'b01,
    KIND_ACK  = 2'b10,
    KIND_NONE = 2'b11
  } reg_kind_e;

endpackage

// File: rtl/grpx_prio.sv
// Lowest-index-first priority encoder
module grpx_prio #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  // R6: the index reported points at a requesting bit
  always_comb begin
    if (found_o) begin
      a_r6_winner_requests: assert (req_i[idx_o]);
    end
  end

endmodule

// File: rtl/grpx_group.sv
// One group: flags, enables, in-flight latch, request pulse
module grpx_group #(
  parameter int SRC = 8,
  localparam int IW = (SRC > 1) ? $clog2(SRC) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SRC-1:0] src_i,
  input  logic           flag_we_i,
  input  logic           en_we_i,
  input  logic           ack_we_i,
  input  logic [SRC-1:0] wdata_i,
  input  logic           take_i,
  output logic [SRC-1:0] flag_o,
  output logic [SRC-1:0] en_o,
  output logic           ack_o,
  output logic           irq_o,
  output logic           win_found_o,
  output logic [IW-1:0]  win_idx_o
);

  logic [SRC-1:0] flag_q, flag_d;
  logic [SRC-1:0] en_q;
  logic           ack_q, ack_d;
  logic           irq_q;
  logic           fire;
  logic           win_found;
  logic [IW-1:0]  win_idx;

  grpx_prio #(.W(SRC)) u_prio (
    .req_i   (flag_q & en_q),
    .found_o (win_found),
    .idx_o   (win_idx)
  );

  assign fire = !ack_q && win_found;

  // next state
  always_comb begin
    flag_d = flag_q;
    if (flag_we_i) flag_d = wdata_i;
    if (take_i && win_found) flag_d[win_idx] = 1'b0;
    flag_d = flag_d | src_i;   // hardware set has last word

    ack_d = ack_q;
    if (ack_we_i && wdata_i[0]) ack_d = 1'b0;
    if (fire) ack_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (en_we_i) en_q <= wdata_i;
      ack_q  <= ack_d;
      irq_q  <= fire;
    end
  end

  assign flag_o      = flag_q;
  assign en_o        = en_q;
  assign ack_o       = ack_q;
  assign irq_o       = irq_q;
  assign win_found_o = win_found;
  assign win_idx_o   = win_idx;

  // R4: a pulse is always accompanied by the latch
  a_r4_pulse_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ack_q);

  // R4: a pulse lasts one cycle
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R5: no pulse while the latch was held
  a_r5_latch_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_q) |-> !irq_q);

  // R2: a raised source is visible as a set flag
  a_r2_hw_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_i) != '0) |-> ((flag_q & $past(src_i)) == $past(src_i)));

endmodule

// File: rtl/grpx_regif.sv
// Address decode and read mux
module grpx_regif #(
  parameter int NGRP = 12,
  parameter int SRC  = 8,
  localparam int GAW = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int AW  = GAW + 2
) (
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [NGRP-1:0][SRC-1:0]  flag_i,
  input  logic [NGRP-1:0][SRC-1:0]  en_i,
  input  logic [NGRP-1:0]           ack_i,
  output logic [NGRP-1:0]           flag_we_o,
  output logic [NGRP-1:0]           en_we_o,
  output logic [NGRP-1:0]           ack_we_o,
  output logic [SRC-1:0]            rdata_o
);

  import grpx_pkg::*;

  reg_kind_e      kind;
  logic [GAW-1:0] grp;

  assign kind = reg_kind_e'(addr_i[AW-1 -: 2]);
  assign grp  = addr_i[GAW-1:0];

  always_comb begin
    flag_we_o = '0;
    en_we_o   = '0;
    ack_we_o  = '0;
    rdata_o   = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp == GAW'(g)) begin
        unique case (kind)
          KIND_FLAG: begin
            flag_we_o[g] = we_i;
            rdata_o      = flag_i[g];
          end
          KIND_EN: begin
            en_we_o[g] = we_i;
            rdata_o    = en_i[g];
          end
          KIND_ACK: begin
            ack_we_o[g] = we_i;
            rdata_o     = SRC'(ack_i[g]);
          end
          default: rdata_o = '0;
        endcase
      end
    end
  end

  // R8: at most one register written per access
  always_comb begin
    a_r8_one_target: assert ($countones({flag_we_o, en_we_o, ack_we_o}) <= 1);
  end

endmodule

// File: rtl/grpx_irq_expander.sv
module grpx_irq_expander #(
  parameter int NGRP    = 12,
  parameter int SRC     = 8,
  parameter int NDIRECT = 4,
  localparam int GAW = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int AW  = GAW + 2,
  localparam int IW  = (SRC > 1) ? $clog2(SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NGRP*SRC-1:0]   src_req,
  input  logic [NDIRECT-1:0]    direct_req,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [SRC-1:0]        reg_wdata,
  output logic [SRC-1:0]        reg_rdata,
  input  logic                  cpu_ack_valid,
  input  logic [GAW-1:0]        cpu_ack_grp,
  output logic                  ack_hit,
  output logic [IW-1:0]         ack_idx,
  output logic [NGRP-1:0]       cpu_irq,
  output logic [NDIRECT-1:0]    cpu_direct
);

  logic [NGRP-1:0][SRC-1:0] flag_all, en_all;
  logic [NGRP-1:0]          ack_all, flag_we, en_we, ack_we, take;
  logic [NGRP-1:0]          win_found;
  logic [NGRP-1:0][IW-1:0]  win_idx;
  logic                     hit_d, hit_q;
  logic [IW-1:0]            idx_d, idx_q;

  grpx_regif #(.NGRP(NGRP), .SRC(SRC)) u_regif (
    .we_i      (reg_we),
    .addr_i    (reg_addr),
    .flag_i    (flag_all),
    .en_i      (en_all),
    .ack_i     (ack_all),
    .flag_we_o (flag_we),
    .en_we_o   (en_we),
    .ack_we_o  (ack_we),
    .rdata_o   (reg_rdata)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign take[g] = cpu_ack_valid && (cpu_ack_grp == GAW'(g));

    grpx_group #(.SRC(SRC)) u_grp (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src_req[g*SRC +: SRC]),
      .flag_we_i   (flag_we[g]),
      .en_we_i     (en_we[g]),
      .ack_we_i    (ack_we[g]),
      .wdata_i     (reg_wdata),
      .take_i      (take[g]),
      .flag_o      (flag_all[g]),
      .en_o        (en_all[g]),
      .ack_o       (ack_all[g]),
      .irq_o       (cpu_irq[g]),
      .win_found_o (win_found[g]),
      .win_idx_o   (win_idx[g])
    );
  end

  // acknowledge response: next state
  always_comb begin
    hit_d = 1'b0;
    idx_d = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (take[g]) begin
        hit_d = win_found[g];
        idx_d = win_idx[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= hit_d;
      if (cpu_ack_valid) idx_q <= idx_d;
    end
  end

  assign ack_hit    = hit_q;
  assign ack_idx    = idx_q;
  assign cpu_direct = direct_req;

  // R6: a hit needs an acknowledge in the previous cycle
  a_r6_hit_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(cpu_ack_valid));

endmodule

// File: tb/grpx_irq_expander_tb.sv
module grpx_irq_expander_tb;

  localparam int NGRP = 12;
  localparam int SRC  = 8;
  localparam int ND   = 4;

  logic                 clk;
  logic                 rst_n;
  logic [NGRP*SRC-1:0]  src_req;
  logic [ND-1:0]        direct_req;
  logic                 reg_we;
  logic [5:0]           reg_addr;
  logic [7:0]           reg_wdata;
  logic [7:0]           reg_rdata;
  logic                 cpu_ack_valid;
  logic [3:0]           cpu_ack_grp;
  logic                 ack_hit;
  logic [2:0]           ack_idx;
  logic [NGRP-1:0]      cpu_irq;
  logic [ND-1:0]        cpu_direct;

  int checks = 0;
  int fails  = 0;

  grpx_irq_expander u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .direct_req(direct_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_ack_valid(cpu_ack_valid),
    .cpu_ack_grp(cpu_ack_grp), .ack_hit(ack_hit), .ack_idx(ack_idx),
    .cpu_irq(cpu_irq), .cpu_direct(cpu_direct)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ad(input logic [1:0] kind, input int g);
    return {kind, 4'(g)};
  endfunction

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_src(input int g, input int s);
    src_req[g*SRC+s] = 1'b1;
    tick();
    src_req = '0;
  endtask

  task automatic cpu_ack(input int g);
    cpu_ack_valid = 1'b1; cpu_ack_grp = 4'(g);
    tick();
    cpu_ack_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(ad(2'b00, 3), d); check("R1 flag", d, 0);
    rd(ad(2'b01, 7), d); check("R1 enable", d, 0);
    rd(ad(2'b10, 11), d); check("R1 latch", d, 0);
    check("R1 cpu_irq", cpu_irq, 0);
  endtask

  task automatic t_masked_then_enable();
    logic [7:0] d;
    pulse_src(2, 5);
    rd(ad(2'b00, 2), d); check("R2 flag set", d, 8'h20);
    tick(); tick();
    check("R3 masked no irq", cpu_irq[2], 0);
    rd(ad(2'b00, 2), d); check("R3 flag held", d, 8'h20);
    wr(ad(2'b01, 2), 8'h20);
    check("R3 no irq yet", cpu_irq[2], 0);
    tick();
    check("R4 irq pulse", cpu_irq[2], 1);
    rd(ad(2'b10, 2), d); check("R4 latch set", d, 1);
    tick();
    check("R4 pulse ends", cpu_irq[2], 0);
  endtask

  task automatic t_latch_hold();
    logic [7:0] d;
    cpu_ack(2);
    check("R6 hit", ack_hit, 1);
    check("R6 idx", ack_idx, 5);
    rd(ad(2'b00, 2), d); check("R6 flag retired", d, 0);
    pulse_src(2, 5);
    for (int i = 0; i < 4; i++) begin
      check("R5 held", cpu_irq[2], 0);
      tick();
    end
    wr(ad(2'b10, 2), 8'h01);
    rd(ad(2'b10, 2), d); check("R5 latch cleared", d, 0);
    check("R5 not yet", cpu_irq[2], 0);
    tick();
    check("R5 re-issue", cpu_irq[2], 1);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(ad(2'b01, 4), 8'h30);
    wr(ad(2'b00, 4), 8'hB0);
    rd(ad(2'b00, 4), d); check("R8 flag overwrite", d, 8'hB0);
    cpu_ack(4);
    check("R6 first hit", ack_hit, 1);
    check("R6 lowest idx", ack_idx, 4);
    rd(ad(2'b00, 4), d); check("R6 only winner cleared", d, 8'hA0);
    cpu_ack(4);
    check("R6 second idx", ack_idx, 5);
    rd(ad(2'b00, 4), d); check("R6 second clear", d, 8'h80);
    cpu_ack(4);
    check("R6 no enabled pending", ack_hit, 0);
    rd(ad(2'b00, 4), d); check("R6 flags untouched", d, 8'h80);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    wr(ad(2'b00, 6), 8'h01);
    reg_we = 1'b1; reg_addr = ad(2'b00, 6); reg_wdata = 8'h00;
    src_req[6*SRC+3] = 1'b1;
    tick();
    reg_we = 1'b0; src_req = '0;
    rd(ad(2'b00, 6), d); check("R2 hw set beats sw clear", d, 8'h08);
  endtask

  task automatic t_direct();
    direct_req = 4'b1010; #1;
    check("R7 direct", cpu_direct, 4'b1010);
    direct_req = 4'b0101; #1;
    check("R7 direct", cpu_direct, 4'b0101);
  endtask

  task automatic t_bad_addr();
    logic [7:0] d;
    wr(ad(2'b00, 12), 8'hFF);
    rd(ad(2'b00, 12), d); check("R8 out of range", d, 0);
    wr(ad(2'b11, 1), 8'hFF);
    rd(ad(2'b11, 1), d); check("R8 kind 3", d, 0);
    rd(ad(2'b00, 1), d); check("R8 no alias", d, 0);
  endtask

  task automatic t_independent();
    wr(ad(2'b01, 9), 8'h01);
    pulse_src(9, 0);
    check("R9 quiet", cpu_irq, 0);
    tick();
    check("R9 only group 9", cpu_irq, 12'h200);
  endtask

  initial begin
    rst_n = 1'b0; src_req = '0; direct_req = '0; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0; cpu_ack_valid = 1'b0; cpu_ack_grp = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_masked_then_enable();
    t_latch_hold();
    t_priority();
    t_set_wins();
    t_direct();
    t_bad_addr();
    t_independent();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule